// File: doc/BRIEF.md
# Capacitor Weight Self-Calibration Engine

This engine works out the digital weight of each capacitor bit in a successive-approximation converter. It runs as a foreground pass after power-on, before any normal conversion. The lowest bits carry fixed nominal weights. Each higher bit is measured in order from low to high, and the measurement uses only the bits below it. To take a measurement, the engine asks the SAR sequencer for a conversion with the bit under test preset, first on its P plate and then on its N plate. The sequencer returns one comparator decision per bit position. The engine turns those decisions into a value by adding the lower weights it already knows.

Each plate is measured 32 times. The engine averages those trials and then merges the two plate results into one weight. Once every weight is known, the engine converts the reference and ground the same way and keeps their difference as the gain-correction word. At the end it streams every weight word, followed by the gain word, into the weight memory, one word per cycle, and then raises done. A pass starts on its own after reset. It waits for the analog balancing step to report completion, and a start pulse runs a new pass once the current one has finished.

Top module: `weight_cal_engine`

## Requirements
- R1: After reset the engine raises no conversion request and stays not busy until `bal_done` is high, and then it starts a pass without any `start` pulse.
- R2: Weight measurement covers bit indices FIXED up to NW-1 in ascending order. For each bit, 32 requests go out with `conv_side`=0 (P plate), then 32 with `conv_side`=1 (N plate). All of them carry `conv_kind`=0 and `conv_bit` set to that index.
- R3: The value of one weight trial is the modulo-2^24 sum of the current weights of the positions j < `conv_bit` where `conv_dec[j]`=1. Decision bits at or above the bit under test have no effect.
- R4: A plate average is the 32-trial sum shifted right by 5, with the remainder discarded.
- R5: A measured bit's weight is (P average + N average + 1) >> 1. Bits above it measure against this new value.
- R6: The weight of each bit i < FIXED is the constant 2^i. These weights are never measured and are written out unchanged.
- R7: After the last weight, 32 requests with `conv_kind`=1 (reference) are followed by 32 with `conv_kind`=2 (ground). Each of these trials sums the weights of all positions whose decision is 1. The gain word is the reference average minus the ground average, modulo 2^24.
- R8: The results are written in NW+1 consecutive cycles to addresses 0 through NW. Address i < NW holds the weight of bit i, and address NW holds the gain word. `mem_we` is low at every other time.
- R9: `done` rises in the cycle after the last write, with `busy` low. It stays high until `start` is pulsed, and that pulse begins a new full pass.
- R10: Once raised, `conv_req` stays high, with `conv_kind`, `conv_bit` and `conv_side` held, until the cycle in which `conv_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bal_done | input | 1 | Analog P/N balancing has finished |
| start | input | 1 | Pulse that runs a new pass after done |
| busy | output | 1 | A pass is measuring or writing |
| done | output | 1 | Results are complete in memory |
| conv_req | output | 1 | Conversion request to the sequencer |
| conv_kind | output | 2 | 0 weight trial, 1 reference, 2 ground |
| conv_bit | output | 5 | Bit index under test |
| conv_side | output | 1 | 0 P plate, 1 N plate |
| conv_ack | input | 1 | Conversion finished, decisions valid |
| conv_dec | input | 27 | Comparator decision per bit position |
| mem_we | output | 1 | Weight memory write strobe |
| mem_addr | output | 5 | Weight memory word address |
| mem_wdata | output | 24 | Weight memory write data |

## Verification
The in-RTL properties check the request handshake hold, the step-by-one address stream, done following the final write, quiet outputs while done, and the range of the bit under test in every cycle. The arithmetic can only be shown by the bench scenarios: the masked sum of lower weights, the truncating average, the rounded P/N merge, the gain difference, and the fixed low weights. The bench's model recomputes every trial from the decisions it hands back, using varied patterns (all ones, all zeros, alternating, pseudo-random, with upper bits set) and random acknowledge delays. It also checks the pass that follows a start pulse.

// File: rtl/weight_cal_engine.sv
module weight_cal_engine #(
  parameter int NW       = 27,
  parameter int FIXED    = 6,
  parameter int W        = 24,
  parameter int AVG_LOG2 = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bal_done,
  input  logic                       start,
  output logic                       busy,
  output logic                       done,
  output logic                       conv_req,
  output logic [1:0]                 conv_kind,
  output logic [$clog2(NW)-1:0]      conv_bit,
  output logic                       conv_side,
  input  logic                       conv_ack,
  input  logic [NW-1:0]              conv_dec,
  output logic                       mem_we,
  output logic [$clog2(NW+1)-1:0]    mem_addr,
  output logic [W-1:0]               mem_wdata
);
  localparam int BW   = $clog2(NW);
  localparam int AW   = $clog2(NW+1);
  localparam int ACCW = W + AVG_LOG2;

  typedef enum logic [2:0] {S_IDLE, S_MEAS, S_SIDE, S_WRITE, S_DONE} st_t;

  st_t                 st;
  logic                pend;
  logic [1:0]          kind;
  logic [BW-1:0]       bitx;
  logic                side;
  logic [AVG_LOG2-1:0] cnt;
  logic [ACCW-1:0]     acc;
  logic [W-1:0]        avg_hold, gain;
  logic [W-1:0]        wt [NW];
  logic [AW-1:0]       widx;

  logic [W-1:0]        samp;
  logic [W-1:0]        avg_now;
  logic [W:0]          mean;

  always_comb begin
    samp = '0;
    for (int j = 0; j < NW; j++)
      if (conv_dec[j] && (kind != 2'd0 || BW'(j) < bitx))
        samp = samp + wt[j];
  end

  assign avg_now = acc[ACCW-1:AVG_LOG2];
  assign mean    = (W+1)'(avg_hold) + (W+1)'(avg_now) + (W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pend     <= 1'b1;
      kind     <= 2'd0;
      bitx     <= BW'(FIXED);
      side     <= 1'b0;
      cnt      <= '0;
      acc      <= '0;
      avg_hold <= '0;
      gain     <= '0;
      widx     <= '0;
      for (int i = 0; i < NW; i++)
        wt[i] <= (i < FIXED) ? (W'(1) << i) : '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) pend <= 1'b1;
          if (pend && bal_done) begin
            pend <= 1'b0;
            kind <= 2'd0;
            bitx <= BW'(FIXED);
            side <= 1'b0;
            cnt  <= '0;
            acc  <= '0;
            st   <= S_MEAS;
          end
        end
        S_MEAS: begin
          if (conv_ack) begin
            acc <= acc + ACCW'(samp);
            cnt <= cnt + 1'b1;
            if (cnt == '1) st <= S_SIDE;
          end
        end
        S_SIDE: begin
          acc <= '0;
          cnt <= '0;
          st  <= S_MEAS;
          case (kind)
            2'd0: begin
              if (!side) begin
                avg_hold <= avg_now;
                side     <= 1'b1;
              end else begin
                wt[bitx] <= mean[W:1];
                side     <= 1'b0;
                if (bitx == BW'(NW-1)) kind <= 2'd1;
                else bitx <= bitx + 1'b1;
              end
            end
            2'd1: begin
              avg_hold <= avg_now;
              kind     <= 2'd2;
            end
            default: begin
              gain <= avg_hold - avg_now;
              widx <= '0;
              st   <= S_WRITE;
            end
          endcase
        end
        S_WRITE: begin
          if (widx == AW'(NW)) st <= S_DONE;
          else widx <= widx + 1'b1;
        end
        S_DONE: begin
          if (start) begin
            pend <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st == S_MEAS) || (st == S_SIDE) || (st == S_WRITE);
  assign done      = (st == S_DONE);
  assign conv_req  = (st == S_MEAS);
  assign conv_kind = kind;
  assign conv_bit  = bitx;
  assign conv_side = side;
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = widx;
  assign mem_wdata = (widx < AW'(NW)) ? wt[widx[BW-1:0]] : gain;

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_ack |=> conv_req && $stable(conv_kind) && $stable(conv_bit) && $stable(conv_side));

  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_addr != AW'(NW) |=> mem_we && mem_addr == AW'($past(mem_addr) + 1'b1));

  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_addr == AW'(NW) |=> done && !busy);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !conv_req && !mem_we);

  a_r2_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_kind == 2'd0 |-> conv_bit >= BW'(FIXED));
endmodule

// File: tb/test_weight_cal_engine.sv
`timescale 1ns/1ps
module test_weight_cal_engine;
  localparam int NW = 27, FIXED = 6, W = 24, NAVG = 32;
  localparam longint MASK = (64'd1 << W) - 1;

  logic clk = 1'b0, rst_n, bal_done, start, conv_ack;
  logic [NW-1:0] conv_dec;
  logic busy, done, conv_req, conv_side, mem_we;
  logic [1:0] conv_kind;
  logic [4:0] conv_bit, mem_addr;
  logic [W-1:0] mem_wdata;

  int checks = 0, failures = 0;
  longint ew [NW];
  longint gain_exp;
  int unsigned rng = 32'h1234_5678;
  int tcount = 0;

  always #2.5 clk = ~clk;

  weight_cal_engine i_weight_cal_engine (
    .clk(clk), .rst_n(rst_n), .bal_done(bal_done), .start(start),
    .busy(busy), .done(done), .conv_req(conv_req), .conv_kind(conv_kind),
    .conv_bit(conv_bit), .conv_side(conv_side), .conv_ack(conv_ack),
    .conv_dec(conv_dec), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned nxt(input int unsigned x);
    int unsigned y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  // one conversion: R2/R7 sequence, R10 hold, R3 sample model
  task automatic do_conv(input int kind, input int b, input int s, output longint val);
    logic [NW-1:0] dec;
    int waitc = 0;
    int d;
    while (!conv_req && waitc < 50) begin
      if (mem_we) chk(1'b0, "R8 early write", 1, 0);
      @(negedge clk); waitc++;
    end
    chk(conv_req && int'(conv_kind) == kind && int'(conv_bit) == b && int'(conv_side) == s,
        (kind == 0) ? "R2 request order" : "R7 request order",
        {conv_req, conv_kind, conv_bit, conv_side}, {1'b1, 2'(kind), 5'(b), 1'(s)});
    rng = nxt(rng);
    d = int'(rng % 3);
    for (int k = 0; k < d; k++) begin
      @(negedge clk);
      if (!conv_req || int'(conv_side) != s || int'(conv_bit) != b)
        chk(1'b0, "R10 request dropped", conv_req, 1);
    end
    rng = nxt(rng);
    case (tcount % 8)
      0: dec = '1;
      1: dec = '0;
      2: dec = 27'h5555555;
      3: dec = 27'h2AAAAAA;
      default: dec = rng[NW-1:0];
    endcase
    tcount++;
    conv_dec = dec;
    conv_ack = 1'b1;
    @(negedge clk);
    conv_ack = 1'b0;
    val = 0;
    for (int j = 0; j < NW; j++)
      if (dec[j] && (kind != 0 || j < b)) val += ew[j];
    val &= MASK;
  endtask

  task automatic run_cal();
    longint acc, v, avg[2], ar;
    for (int i = 0; i < FIXED; i++) ew[i] = 64'd1 << i;
    for (int b = FIXED; b < NW; b++) begin
      for (int s = 0; s < 2; s++) begin
        acc = 0;
        for (int t = 0; t < NAVG; t++) begin
          do_conv(0, b, s, v);
          acc += v;
        end
        avg[s] = (acc >> 5) & MASK;           // R4 truncating average
      end
      ew[b] = ((avg[0] + avg[1] + 1) >> 1) & MASK;  // R5 rounded merge
    end
    acc = 0;
    for (int t = 0; t < NAVG; t++) begin do_conv(1, NW-1, 0, v); acc += v; end
    ar = (acc >> 5) & MASK;
    acc = 0;
    for (int t = 0; t < NAVG; t++) begin do_conv(2, NW-1, 0, v); acc += v; end
    gain_exp = (ar - ((acc >> 5) & MASK)) & MASK;
    for (int k = 0; k < 10 && !mem_we; k++) @(negedge clk);
    for (int i = 0; i <= NW; i++) begin
      chk(mem_we && int'(mem_addr) == i, "R8 write address", mem_addr, i);
      if (i == NW)
        chk(longint'(mem_wdata) == gain_exp, "R7 gain word", mem_wdata, gain_exp);
      else if (i < FIXED)
        chk(longint'(mem_wdata) == ew[i], "R6 fixed weight", mem_wdata, ew[i]);
      else
        chk(longint'(mem_wdata) == ew[i], "R5 weight word (R3 R4)", mem_wdata, ew[i]);
      @(negedge clk);
    end
    chk(done && !busy && !mem_we && !conv_req, "R9 done after last write",
        {done, busy, mem_we}, 3'b100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bal_done = 1'b0; start = 1'b0; conv_ack = 1'b0; conv_dec = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !conv_req && !mem_we, "R1 reset state",
        {busy, done, conv_req, mem_we}, 0);
    rst_n = 1'b1;
    begin
      bit quiet = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (conv_req || busy || mem_we) quiet = 1'b0;
      end
      chk(quiet, "R1 waits for balance", !quiet, 0);
    end
    bal_done = 1'b1;
    run_cal();
    begin
      bit held = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (!done || conv_req || mem_we) held = 1'b0;
      end
      chk(held, "R9 done holds", !held, 0);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run_cal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule